// File: doc/BRIEF.md
# Shift Queue with In-Place Entry Invalidation

This block is a fixed-depth first-in first-out buffer built as a shift register. Slot 0 is always the head. When the head leaves, every occupied slot moves one position toward the head. A producer writes through a valid/ready enqueue port and a consumer reads through a valid/ready dequeue port. Every slot's contents and liveness are exported, indexed from the head, so that neighbouring logic, such as a request merger, can inspect pending entries.

That neighbouring logic can cancel any stored entry in place with a per-slot invalidate vector, which is also indexed from the head. A cancelled entry keeps its slot, so the queue can hold holes. Occupancy is therefore tracked with a separate contiguous used mask rather than inferred from the liveness bits. A cancelled entry that reaches the head is discarded without any consumer handshake, at one entry per cycle. The dequeue valid output is taken only from registered state, so an invalidate never feeds back combinationally into it.

Top module: `shq_top`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and every bit of slot_live is 0.
- R2: Live entries leave on the dequeue port in the order in which they were accepted. The used slots always form a contiguous run starting at slot 0.
- R3: in_ready is 1 when at least one slot is unused or the head leaves in the current cycle. When all slots are used and the head is live, not invalidated and out_ready is 0, in_ready is 0.
- R4: When the queue is full and the head is being dequeued, an enqueue in the same cycle is accepted and the queue stays full.
- R5: An enqueue into an empty queue is never lost, whatever the level of out_ready. The entry is on the dequeue port in the next cycle.
- R6: Asserting kill[i] for an occupied slot i makes that entry non-live from the next cycle. The entry never appears on the dequeue port. A kill bit for an unused slot has no effect.
- R7: When the head slot is used but not live, it is removed at the next clock edge without a handshake, one entry per cycle.
- R8: Asserting kill[0] removes the head entry by the next cycle, whatever the level of out_ready.
- R9: out_valid is 1 exactly when slot 0 is used and live in registered state. Asserting kill[0] does not lower out_valid in the same cycle.
- R10: An enqueue made in the same cycle that the last occupied entry is invalidated is accepted and placed behind that entry. It is delivered after the live entries ahead of it.
- R11: slot_data bits [i*WIDTH +: WIDTH] and slot_live[i] show slot i counted from the head. out_data equals slot 0 whenever out_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers an entry |
| in_ready | output | 1 | Queue accepts the offered entry this cycle |
| in_data | input | WIDTH | Entry payload |
| out_valid | output | 1 | Live entry present at the head |
| out_ready | input | 1 | Consumer takes the head entry |
| out_data | output | WIDTH | Head entry payload |
| kill | input | DEPTH | Per-slot invalidate, bit i is slot i from the head |
| slot_data | output | DEPTH*WIDTH | All slot payloads, slot i at bits [i*WIDTH +: WIDTH] |
| slot_live | output | DEPTH | Per-slot live flag, slot i from the head |

## Verification
The hardest case to reach from the ports is a run of consecutive dead entries at the head while new entries still arrive behind them. That case needs a full queue, a consumer that stays stalled while several kill bits fire in one cycle, and then a release that lets the automatic drops run one per cycle. Directed phases set up that case, along with the invalidated-tail enqueue and the empty-queue enqueue with ready high. Pseudo-random sweeps then vary enqueue, ready and sparse kill patterns against a behavioural model in the bench, which checks every port on every cycle.

// File: rtl/shq_pkg.sv
package shq_pkg;

  // number of set bits in an occupancy mask (zero-extended to 32 bits)
  function automatic int unsigned ones_count(input logic [31:0] m);
    int unsigned c;
    c = 0;
    for (int i = 0; i < 32; i++) c += int'(m[i]);
    return c;
  endfunction

  // slot that an accepted entry lands in, after the optional shift
  function automatic int unsigned tail_index(input int unsigned occupied,
                                             input logic shifting);
    return occupied - int'(shifting);
  endfunction

endpackage

// File: rtl/shq_ctrl.sv
module shq_ctrl #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] used,
  input  logic             head_live,
  input  logic             head_kill,
  input  logic             out_ready,
  input  logic             in_valid,
  output logic             shift,
  output logic             in_ready,
  output logic             push,
  output logic [DEPTH-1:0] wr_sel
);
  import shq_pkg::*;

  logic [CW-1:0] occ;
  logic [CW-1:0] wpos;

  // head leaves on handshake, when already dead, or when killed now;
  // an empty queue never shifts (used[0] gate)
  assign shift    = used[0] & (~head_live | out_ready | head_kill);
  assign in_ready = ~used[DEPTH-1] | shift;
  assign push     = in_valid & in_ready;

  assign occ  = CW'(ones_count(32'(used)));
  assign wpos = CW'(tail_index(32'(occ), shift));

  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    assign wr_sel[i] = push & (wpos == CW'(i));
  end
endmodule

// File: rtl/shq_slot.sv
module shq_slot #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             wr,
  input  logic [WIDTH-1:0] din,
  input  logic             kill,
  input  logic             up_used,
  input  logic             up_live,
  input  logic             up_kill,
  input  logic [WIDTH-1:0] up_data,
  output logic             used,
  output logic             live,
  output logic [WIDTH-1:0] data
);
  logic             n_used, n_live;
  logic [WIDTH-1:0] n_data;

  always_comb begin
    if (shift) begin
      n_used = up_used;
      n_live = up_live & ~up_kill;
      n_data = up_data;
    end else begin
      n_used = used;
      n_live = live & ~kill;
      n_data = data;
    end
    if (wr) begin
      n_used = 1'b1;
      n_live = 1'b1;
      n_data = din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= 1'b0;
      live <= 1'b0;
      data <= '0;
    end else begin
      used <= n_used;
      live <= n_live;
      data <= n_data;
    end
  end
endmodule

// File: rtl/shq_top.sv
module shq_top #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [WIDTH-1:0]       in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [WIDTH-1:0]       out_data,
  input  logic [DEPTH-1:0]       kill,
  output logic [DEPTH*WIDTH-1:0] slot_data,
  output logic [DEPTH-1:0]       slot_live
);
  logic [DEPTH-1:0] used_v;
  logic [DEPTH-1:0] live_v;
  logic [WIDTH-1:0] data_a [DEPTH];
  logic [DEPTH-1:0] wr_sel;
  logic             shift;
  logic             push;

  shq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .used      (used_v),
    .head_live (live_v[0]),
    .head_kill (kill[0]),
    .out_ready (out_ready),
    .in_valid  (in_valid),
    .shift     (shift),
    .in_ready  (in_ready),
    .push      (push),
    .wr_sel    (wr_sel)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic             up_used, up_live, up_kill;
    logic [WIDTH-1:0] up_data;
    if (i < DEPTH - 1) begin : g_mid
      assign up_used = used_v[i+1];
      assign up_live = live_v[i+1];
      assign up_kill = kill[i+1];
      assign up_data = data_a[i+1];
    end else begin : g_end
      assign up_used = 1'b0;
      assign up_live = 1'b0;
      assign up_kill = 1'b0;
      assign up_data = '0;
    end

    shq_slot #(.WIDTH(WIDTH)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift   (shift),
      .wr      (wr_sel[i]),
      .din     (in_data),
      .kill    (kill[i]),
      .up_used (up_used),
      .up_live (up_live),
      .up_kill (up_kill),
      .up_data (up_data),
      .used    (used_v[i]),
      .live    (live_v[i]),
      .data    (data_a[i])
    );

    assign slot_data[i*WIDTH +: WIDTH] = data_a[i];
  end

  assign slot_live = live_v;
  assign out_valid = used_v[0] & live_v[0];
  assign out_data  = data_a[0];
endmodule

// File: rtl/shq_chk.sv
module shq_chk #(
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_ready,
  input logic [DEPTH-1:0] kill,
  input logic [DEPTH-1:0] slot_live,
  input logic [DEPTH-1:0] used,
  input logic             shift_evt,
  input logic             push_evt
);
  // R2
  used_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((used + 1'b1) & used) == '0);

  // R3
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (used[DEPTH-1] && slot_live[0] && !kill[0] && !out_ready) |-> !in_ready);

  // R4
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (used[DEPTH-1] && shift_evt && push_evt) |=> used[DEPTH-1]);

  // R5
  empty_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!used[0] && in_valid) |=> (used[0] && slot_live[0]));

  // R7
  dead_head_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (used[0] && !slot_live[0]) |-> shift_evt);

  // R8
  head_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (used[0] && kill[0] && !in_valid && !used[1]) |=> !used[0]);

  // R6
  if (DEPTH >= 3) begin : g_k
    mid_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kill[1] && used[1] && !shift_evt) |=> !slot_live[1]);
    mid_kill_sh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kill[1] && used[1] && shift_evt) |=> !slot_live[0]);
  end
endmodule

bind shq_top shq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_ready (out_ready),
  .kill      (kill),
  .slot_live (slot_live),
  .used      (used_v),
  .shift_evt (shift),
  .push_evt  (push)
);

// File: tb/sim_shq_top.sv
`timescale 1ns/1ps
module sim_shq_top;
  localparam int D = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [D-1:0] kill = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_data;
  logic [D*W-1:0] slot_data;
  logic [D-1:0] slot_live;

  shq_top #(.DEPTH(D), .WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .kill(kill), .slot_data(slot_data),
    .slot_live(slot_live)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  logic [W-1:0] md [D];
  bit ml [D];
  int mn = 0;
  logic [15:0] lf = 16'hACE1;
  logic [W-1:0] seq = 8'h10;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=50000", cyc);
      finish_run();
    end
  end

  // one cycle: drive, compare against model, advance model
  task automatic step(input string tag, input bit iv, input logic [W-1:0] id,
                      input bit ordy, input logic [D-1:0] kl);
    bit ov, pop, ir;
    @(negedge clk);
    in_valid = iv; in_data = id; out_ready = ordy; kill = kl;
    #0.5;
    ov  = (mn > 0) && ml[0];
    pop = (mn > 0) && (!ml[0] || ordy || kl[0]);
    ir  = (mn < D) || pop;
    chk(tag, "in_ready", int'(in_ready), int'(ir));
    chk(tag, "out_valid", int'(out_valid), int'(ov));
    if (ov) chk(tag, "out_data", int'(out_data), int'(md[0]));
    for (int i = 0; i < D; i++) begin
      chk(tag, "slot_live", int'(slot_live[i]), (i < mn) ? int'(ml[i]) : 0);
      if (i < mn && ml[i])
        chk(tag, "slot_data", int'(slot_data[i*W +: W]), int'(md[i]));
    end
    for (int i = 0; i < D; i++) if (i < mn && kl[i]) ml[i] = 0;
    if (pop) begin
      for (int i = 0; i < D - 1; i++) begin md[i] = md[i+1]; ml[i] = ml[i+1]; end
      mn--;
    end
    if (iv && ir) begin md[mn] = id; ml[mn] = 1; mn++; end
  endtask

  task automatic drain(input string tag);
    for (int k = 0; k < 3 * D && mn > 0; k++) step(tag, 0, 8'h00, 1, '0);
  endtask

  task automatic nxt();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    // R1 reset state
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "in_ready", int'(in_ready), 1);
    chk("R1", "slot_live", int'(slot_live), 0);

    // R5: enqueue into empty with ready high, then again with ready low
    step("R5", 1, 8'hA1, 1, '0);
    step("R5", 0, 8'h00, 1, '0);
    step("R5", 1, 8'hA2, 0, '0);
    step("R5", 0, 8'h00, 0, '0);
    drain("R5");

    // R3/R4: fill, stall, then swap while full
    for (int k = 0; k < D; k++) step("R3", 1, 8'hB0 + 8'(k), 0, '0);
    step("R3", 1, 8'hBF, 0, '0);
    step("R4", 1, 8'hC0, 1, '0);
    step("R4", 1, 8'hC1, 1, '0);
    step("R11", 0, 8'h00, 0, '0);

    // R8/R9: kill head while stalled; out_valid stays up that cycle
    step("R8/R9", 0, 8'h00, 0, 4'b0001);
    step("R8/R9", 0, 8'h00, 0, '0);
    // R6: kill a middle slot plus an unused-slot kill bit
    step("R6", 0, 8'h00, 0, 4'b1010);
    step("R6", 0, 8'h00, 0, '0);
    drain("R6");

    // R7: full queue, several dead heads at once, then consecutive drops
    for (int k = 0; k < D; k++) step("R7", 1, 8'hD0 + 8'(k), 0, '0);
    step("R7", 0, 8'h00, 0, 4'b0111);
    step("R7", 1, 8'hDA, 0, '0);
    step("R7", 1, 8'hDB, 0, '0);
    step("R7", 0, 8'h00, 0, '0);
    drain("R7");

    // R10: enqueue while the tail entry is invalidated
    step("R10", 1, 8'hE0, 0, '0);
    step("R10", 1, 8'hE1, 0, '0);
    step("R10", 1, 8'hE2, 0, 4'b0010);
    step("R10", 1, 8'hE3, 0, 4'b0100);
    drain("R10");

    // R2: pseudo-random sweeps with different ready bias
    for (int ph = 0; ph < 3; ph++) begin
      for (int k = 0; k < 400; k++) begin
        bit iv, ordy;
        logic [D-1:0] kl;
        nxt();
        iv   = lf[0] | lf[1];
        ordy = (ph == 0) ? (lf[2] & lf[3]) : (ph == 1) ? lf[2] : (lf[2] | lf[3]);
        kl   = (lf[7:5] == 3'd0) ? lf[11:8] : '0;
        seq  = seq + 8'd1;
        step("R2", iv, seq, ordy, kl);
      end
    end
    drain("R2");
    finish_run();
  end
endmodule